// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block is the arithmetic core of a small 8-bit processor datapath. On every rising clock edge it takes two operands and a carry input. It either adds them or subtracts the second from the first, and it registers the result with four status flags. A mode input chooses between plain two's-complement arithmetic and packed binary-coded-decimal arithmetic, in which each 4-bit nibble holds one decimal digit.

The caller decides where the first operand comes from. It may be the accumulator or a memory byte reached through an index register, and that choice is made outside this block. The width is set as a number of decimal digits, and the default of two digits gives an 8-bit datapath.

In decimal mode the correction is applied one nibble at a time. A digit that passes nine is brought back into range, and the correction ripples into the next digit. The carry output of a subtraction means that no borrow occurred. The overflow flag follows the arithmetic that the hardware actually performs, so in a decimal add it is taken from the uncorrected nibble sums.

Top module: `bcd_addsub_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first clock edge, the outputs read result 0, carry 0, overflow 0, negative 0 and zero 1.
- R2: The outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge (one cycle of latency).
- R3: With `decimal_i`=0 and `subtract_i`=0, {carry, result} equals A+B+carry_in. Overflow is bit 7 of (R^A)&(R^B).
- R4: With `decimal_i`=0 and `subtract_i`=1, {carry, result} equals A+~B+carry_in, so carry 1 means no borrow. Overflow is bit 7 of (R^A)&(R^~B).
- R5: With `decimal_i`=1 and `subtract_i`=0, and both operands valid BCD (every nibble 0..9), the result is the BCD encoding of (A+B+carry_in) mod 100. Carry is 1 exactly when that sum reaches 100.
- R6: In a decimal add, overflow is bit 7 of (P^A)&(P^B). Each nibble of P is the low four bits of the uncorrected sum of that digit pair plus the carry into that digit.
- R7: With `decimal_i`=1 and `subtract_i`=1, and valid BCD operands, borrow_in = ~carry_in. The result is the BCD encoding of (A-B-borrow_in) mod 100, and carry is 1 exactly when that difference is not negative.
- R8: In a decimal subtract, overflow is bit 7 of (D^A)&(~D^B), where D is the plain 8-bit binary difference A-B-borrow_in.
- R9: In decimal mode the correction works on each nibble, including non-decimal digits. An add nibble sum of 10 or more has 6 added, is kept to four bits and carries 1 into the next digit. A subtract nibble difference below zero has 6 taken away, is kept to four bits and borrows 1 from the next digit.
- R10: In every mode, negative equals result bit 7 (the top bit), and zero is 1 exactly when the whole result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 8 | First operand A (4*DIGITS bits) |
| opb_i | input | 8 | Second operand B (4*DIGITS bits) |
| carry_i | input | 1 | Carry input; for subtraction 1 means no borrow |
| decimal_i | input | 1 | 1 selects packed-BCD arithmetic, 0 selects binary |
| subtract_i | input | 1 | 1 selects A minus B, 0 selects A plus B |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry out (no-borrow for subtraction) |
| overflow_o | output | 1 | Registered signed overflow |
| negative_o | output | 1 | Registered result top bit |
| zero_o | output | 1 | Registered all-zero indicator |

## Verification
Every output is one register stage away from the inputs, so a fault in the digit correction, the carry chain or the flag logic is visible on the very next clock edge after the operands that trigger it. A missing +6 or -6 adjust only shows when a nibble sum crosses nine or a nibble difference goes negative. A broken carry link between digits only shows when the low digit produces a carry or borrow. For these reasons the decimal operand space is swept completely for both carry values and both operations, and binary mode is swept across every first operand. An overflow computed from the corrected sum rather than the uncorrected one differs only on some decimal additions, so the decimal overflow is compared on every vector.

// File: rtl/alu_bcd_pkg.sv
package alu_bcd_pkg;

    localparam int unsigned NIB_W   = 4;
    localparam int unsigned DIG_MAX = 9;
    localparam int unsigned DIG_FIX = 6;

    typedef enum logic [1:0] {
        MODE_BIN_ADD = 2'b00,
        MODE_BIN_SUB = 2'b01,
        MODE_DEC_ADD = 2'b10,
        MODE_DEC_SUB = 2'b11
    } alu_mode_e;

endpackage

// File: rtl/bin_addsub.sv
module bin_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic [W-1:0] ovf_vec;

    always_comb begin
        b_eff   = sub ? ~op_b : op_b;
        wide    = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum     = wide[W-1:0];
        cout    = wide[W];
        ovf_vec = (wide[W-1:0] ^ op_a) & (wide[W-1:0] ^ b_eff);
        ovf     = ovf_vec[W-1];
    end

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import alu_bcd_pkg::*;
(
    input  logic [NIB_W-1:0] dig_a,
    input  logic [NIB_W-1:0] dig_b,
    input  logic             link_in,
    input  logic             sub,
    output logic [NIB_W-1:0] dig_r,
    output logic [NIB_W-1:0] dig_p,
    output logic             link_out
);
    logic [NIB_W:0] add_w;
    logic [NIB_W:0] add_fix;
    logic [NIB_W:0] sub_w;
    logic           add_big;
    logic           sub_neg;

    always_comb begin
        add_w   = {1'b0, dig_a} + {1'b0, dig_b} + {{NIB_W{1'b0}}, link_in};
        add_fix = add_w + (NIB_W+1)'(DIG_FIX);
        add_big = (add_w > (NIB_W+1)'(DIG_MAX));
        sub_w   = {1'b0, dig_a} - {1'b0, dig_b} - {{NIB_W{1'b0}}, link_in};
        sub_neg = sub_w[NIB_W];
        if (sub) begin
            dig_r    = sub_neg ? (sub_w[NIB_W-1:0] - NIB_W'(DIG_FIX)) : sub_w[NIB_W-1:0];
            link_out = sub_neg;
            dig_p    = sub_w[NIB_W-1:0];
        end else begin
            dig_r    = add_big ? add_fix[NIB_W-1:0] : add_w[NIB_W-1:0];
            link_out = add_big;
            dig_p    = add_w[NIB_W-1:0];
        end
    end

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
    import alu_bcd_pkg::*;
#(
    parameter int unsigned DIGITS = 2
) (
    input  logic [NIB_W*DIGITS-1:0] op_a,
    input  logic [NIB_W*DIGITS-1:0] op_b,
    input  logic                    cin,
    input  logic                    sub,
    output logic [NIB_W*DIGITS-1:0] res,
    output logic                    cout,
    output logic                    ovf
);
    localparam int unsigned W = NIB_W * DIGITS;

    logic [DIGITS:0] link;
    logic [W-1:0]    partial;
    logic [W-1:0]    raw_diff;
    logic [W-1:0]    add_ov_vec;
    logic [W-1:0]    sub_ov_vec;

    assign link[0] = sub ? ~cin : cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit u_digit (
            .dig_a    (op_a[g*NIB_W +: NIB_W]),
            .dig_b    (op_b[g*NIB_W +: NIB_W]),
            .link_in  (link[g]),
            .sub      (sub),
            .dig_r    (res[g*NIB_W +: NIB_W]),
            .dig_p    (partial[g*NIB_W +: NIB_W]),
            .link_out (link[g+1])
        );
    end

    always_comb begin
        raw_diff   = op_a - op_b - {{(W-1){1'b0}}, ~cin};
        add_ov_vec = (partial ^ op_a) & (partial ^ op_b);
        sub_ov_vec = (raw_diff ^ op_a) & (~raw_diff ^ op_b);
        ovf        = sub ? sub_ov_vec[W-1] : add_ov_vec[W-1];
        cout       = sub ? ~link[DIGITS] : link[DIGITS];
    end

endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu
    import alu_bcd_pkg::*;
#(
    parameter int unsigned DIGITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NIB_W*DIGITS-1:0] opa_i,
    input  logic [NIB_W*DIGITS-1:0] opb_i,
    input  logic                    carry_i,
    input  logic                    decimal_i,
    input  logic                    subtract_i,
    output logic [NIB_W*DIGITS-1:0] result_o,
    output logic                    carry_o,
    output logic                    overflow_o,
    output logic                    negative_o,
    output logic                    zero_o
);
    localparam int unsigned W = NIB_W * DIGITS;

    typedef struct packed {
        logic [W-1:0] res;
        logic         c;
        logic         v;
        logic         n;
        logic         z;
    } alu_state_t;

    localparam alu_state_t RESET_STATE = '{res: '0, c: 1'b0, v: 1'b0, n: 1'b0, z: 1'b1};

    logic [W-1:0] bin_sum;
    logic         bin_c;
    logic         bin_v;
    logic [W-1:0] dec_sum;
    logic         dec_c;
    logic         dec_v;
    alu_mode_e    mode;
    alu_state_t   st_d;
    alu_state_t   st_q;
    logic         primed_d;
    logic         primed_q;

    bin_addsub #(.W(W)) u_bin (
        .op_a (opa_i),
        .op_b (opb_i),
        .cin  (carry_i),
        .sub  (subtract_i),
        .sum  (bin_sum),
        .cout (bin_c),
        .ovf  (bin_v)
    );

    bcd_chain #(.DIGITS(DIGITS)) u_dec (
        .op_a (opa_i),
        .op_b (opb_i),
        .cin  (carry_i),
        .sub  (subtract_i),
        .res  (dec_sum),
        .cout (dec_c),
        .ovf  (dec_v)
    );

    always_comb begin
        mode     = alu_mode_e'({decimal_i, subtract_i});
        st_d     = st_q;
        primed_d = 1'b1;
        unique case (mode)
            MODE_BIN_ADD, MODE_BIN_SUB: begin
                st_d.res = bin_sum;
                st_d.c   = bin_c;
                st_d.v   = bin_v;
            end
            MODE_DEC_ADD, MODE_DEC_SUB: begin
                st_d.res = dec_sum;
                st_d.c   = dec_c;
                st_d.v   = dec_v;
            end
            default: st_d = st_q;
        endcase
        st_d.n = st_d.res[W-1];
        st_d.z = (st_d.res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= RESET_STATE;
            primed_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            primed_q <= primed_d;
        end
    end

    assign result_o   = st_q.res;
    assign carry_o    = st_q.c;
    assign overflow_o = st_q.v;
    assign negative_o = st_q.n;
    assign zero_o     = st_q.z;

    function automatic logic all_digits_ok(input logic [W-1:0] val);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < DIGITS; k++) begin
            if (val[k*NIB_W +: NIB_W] > NIB_W'(DIG_MAX)) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0)); // R10

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        negative_o == result_o[W-1]); // R10

    AST_BIN_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && !$past(decimal_i) && !$past(subtract_i) |->
        {carry_o, result_o} == ((W+1)'($past(opa_i)) + (W+1)'($past(opb_i))
                                + (W+1)'($past(carry_i)))); // R3

    AST_BIN_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && !$past(decimal_i) && $past(subtract_i) |->
        carry_o == ((W+1)'($past(opa_i)) >= ((W+1)'($past(opb_i))
                                             + (W+1)'(!$past(carry_i))))); // R4

    AST_DEC_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(decimal_i) && all_digits_ok($past(opa_i))
        && all_digits_ok($past(opb_i)) |-> all_digits_ok(result_o)); // R5

endmodule

// File: tb/bcd_addsub_alu_tb_top.sv
`timescale 1ns/1ps
module bcd_addsub_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic       cin = 1'b0;
    logic       dec = 1'b0;
    logic       sub = 1'b0;
    logic [7:0] res;
    logic       cout, ovf, neg, zer;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bcd_addsub_alu #(.DIGITS(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .opa_i      (opa),
        .opb_i      (opb),
        .carry_i    (cin),
        .decimal_i  (dec),
        .subtract_i (sub),
        .result_o   (res),
        .carry_o    (cout),
        .overflow_o (ovf),
        .negative_o (neg),
        .zero_o     (zer)
    );

    function automatic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic compare(input string tag, input [7:0] er, input ec, input ev);
        logic en, ez;
        en = er[7];
        ez = (er == 8'h00);
        checks++;
        if (res !== er || cout !== ec || ovf !== ev || neg !== en || zer !== ez) begin
            failures++;
            $display("FAIL %s: a=%h b=%h c=%b dec=%b sub=%b got r=%h c=%b v=%b n=%b z=%b expected r=%h c=%b v=%b n=%b z=%b",
                     tag, opa, opb, cin, dec, sub, res, cout, ovf, neg, zer, er, ec, ev, en, ez);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, check at the next falling edge.
    task automatic apply(input [7:0] a, input [7:0] b, input c, input d, input s,
                         input string tag, input [7:0] er, input ec, input ev);
        opa = a; opb = b; cin = c; dec = d; sub = s;
        @(negedge clk);
        compare(tag, er, ec, ev);
    endtask

    task automatic bin_vec(input [7:0] a, input [7:0] b, input c, input s);
        logic [7:0] be;
        logic [8:0] w;
        logic [7:0] ov;
        be = s ? ~b : b;
        w  = 9'(a) + 9'(be) + 9'(c);
        ov = (w[7:0] ^ a) & (w[7:0] ^ be);
        apply(a, b, c, 1'b0, s, s ? "R4 binary subtract, R10 flags" : "R3 binary add, R10 flags",
              w[7:0], w[8], ov[7]);
    endtask

    task automatic dec_vec(input int va, input int vb, input c, input s);
        logic [7:0] a, b, er, pp, dd, ov;
        int sum, lo, lc, hi;
        a = to_bcd(va);
        b = to_bcd(vb);
        if (!s) begin
            sum = va + vb + int'(c);
            er  = to_bcd(sum % 100);
            lo  = (va % 10) + (vb % 10) + int'(c);
            lc  = (lo >= 10) ? 1 : 0;
            hi  = (va / 10) + (vb / 10) + lc;
            pp  = 8'(((hi % 16) * 16) + (lo % 16));
            ov  = (pp ^ a) & (pp ^ b);
            apply(a, b, c, 1'b1, 1'b0, "R5/R6 decimal add", er, sum >= 100, ov[7]);
        end else begin
            sum = va - vb - (1 - int'(c));
            er  = to_bcd((sum + 100) % 100);
            dd  = a - b - 8'(!c);
            ov  = (dd ^ a) & (~dd ^ b);
            apply(a, b, c, 1'b1, 1'b1, "R7/R8 decimal subtract", er, sum >= 0, ov[7]);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1: reset values, both during reset and before the first edge after release
        compare("R1 reset state", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        #1;
        compare("R1 reset state after release", 8'h00, 1'b0, 1'b0);
        @(negedge clk);

        // R2: one cycle of latency, outputs hold until the next rising edge
        apply(8'h12, 8'h34, 1'b0, 1'b0, 1'b0, "R2 latency first vector", 8'h46, 1'b0, 1'b0);
        opa = 8'hFF; opb = 8'h01; cin = 1'b1;
        #2;
        compare("R2 outputs held before edge", 8'h46, 1'b0, 1'b0);
        @(negedge clk);
        compare("R2 outputs after edge", 8'h01, 1'b1, 1'b0);

        // R9: non-decimal digits, adjusted nibble by nibble
        apply(8'h0F, 8'h01, 1'b0, 1'b1, 1'b0, "R9 decimal add hex digit", 8'h16, 1'b0, 1'b0);
        apply(8'h00, 8'h0F, 1'b1, 1'b1, 1'b1, "R9 decimal subtract hex digit", 8'h9B, 1'b0, 1'b0);

        // R10: zero and negative corner cases
        apply(8'h99, 8'h01, 1'b0, 1'b1, 1'b0, "R10 decimal wrap to zero", 8'h00, 1'b1, 1'b0);
        apply(8'h80, 8'h80, 1'b0, 1'b0, 1'b0, "R10 binary zero with overflow", 8'h00, 1'b1, 1'b1);

        // R5..R8: all valid BCD operand pairs, both carries, both operations
        for (int ai = 0; ai < 100; ai++)
            for (int bi = 0; bi < 100; bi++)
                for (int ci = 0; ci < 2; ci++)
                    for (int si = 0; si < 2; si++)
                        dec_vec(ai, bi, 1'(ci), 1'(si));

        // R3/R4: every first operand against a spread of second operands
        for (int ai = 0; ai < 256; ai++)
            for (int bi = 0; bi < 16; bi++)
                for (int ci = 0; ci < 2; ci++)
                    for (int si = 0; si < 2; si++)
                        bin_vec(8'(ai), 8'((bi * 17) ^ (ai & 8'h0F)), 1'(ci), 1'(si));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule